// File: doc/BRIEF.md
# Shared interrupt line router

The router merges level-sensitive interrupt requests from a grid of PCI device slots (each slot has four pins) and from a set of legacy lines. It turns them into edge strobes toward an I/O APIC model and a legacy PIC model. Every global system interrupt (GSI) keeps a reference count of the requesters currently holding it, and each of the four PCI links keeps one as well. Edges are produced only when a count moves between zero and one, so any number of requesters can share a GSI without producing repeated edges.

A small routing table steers each PCI link onto a legacy IRQ number, with zero meaning that the link is disconnected. The table can be rewritten while the link is live. In that case the assertion moves from the old IRQ to the new one over two cycles.

Requests arrive one at a time on a valid/ready port. Each request carries an operation code and the operands that the operation needs.

Top module: `irq_router`

## Requirements
- R1: After reset every latch bit, count and route is zero, all edge outputs are low and `op_ready` is high.
- R2: Each PCI pin has one latch bit at index dev*4+pin. An assert of a pin that is already set has no effect, and a deassert of a pin that is already clear has no effect: no edges are produced and no count changes.
- R3: A PCI pin assert increments the count of its direct GSI 16 + ((dev*4+pin) mod 32). Bit g of `apic_rise` pulses only when that count goes from 0 to 1. The direct GSI never produces a PIC edge.
- R4: A PCI pin also increments the count of link (dev+pin) mod 4. When the link count leaves 0 and the link's route r is nonzero, the count of GSI r increments, and if that count leaves 0, bit r of both `apic_rise` and `pic_rise` pulses.
- R5: A deassert decrements the same counts. Bit r of `pic_fall` pulses only when the count of legacy GSI r returns to 0. A direct GSI returning to 0 gives no edge.
- R6: A route of 0 disconnects the link, so no legacy count or edge follows from that link.
- R7: Legacy line n (0..15) has its own latch bit and shares the count of GSI n. A 0-to-1 transition pulses bit n of `apic_rise` and `pic_rise`, and a return to 0 pulses bit n of `pic_fall`. Repeated asserts or deasserts of the line are ignored.
- R8: A route write with the current value does nothing. When the link count is nonzero, the first cycle decrements the old IRQ (PIC fall if it reaches 0). For a nonzero new IRQ, the next cycle increments it (rising on both sides at 1), and `op_ready` is low during that cycle.
- R9: A route value above 15 is rejected and leaves the table unchanged.
- R10: A request is accepted when `op_valid` and `op_ready` are both high. The op codes are 1 for PCI assert, 2 for PCI deassert, 3 for legacy assert, 4 for legacy deassert and 5 for route write; any other code is ignored. The resulting edges appear in the cycle after acceptance, and without a request no edges appear.
- R11: Each count tracks every holder of its GSI (a legacy line and several links may hold one IRQ together) and never wraps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| op_valid | input | 1 | Request present |
| op_ready | output | 1 | Router can accept a request this cycle |
| op_code | input | 3 | Operation code (see R10) |
| op_dev | input | 5 | PCI device slot |
| op_pin | input | 2 | PCI pin of the slot |
| op_isa | input | 4 | Legacy line number |
| op_link | input | 2 | Link whose route is written |
| op_route | input | 5 | New route value; values above 15 are illegal |
| apic_rise | output | 48 | One-cycle rising-edge strobes toward the APIC, bit = GSI |
| pic_rise | output | 16 | One-cycle rising-edge strobes toward the PIC, bit = IRQ |
| pic_fall | output | 16 | One-cycle falling-edge strobes toward the PIC, bit = IRQ |

## Verification
A count that drifts from the true number of holders never shows up at the moment of the error. It appears only when that GSI next crosses zero. A count that is too high swallows the PIC falling edge at the last release. A count that is too low produces an early falling edge, or a second rising edge when the next requester arrives. The bench therefore drives every pin through complete assert and release sweeps, moves live routes, and lets shared IRQs pass through several holders. This way, a drifted count shows up as a missing or extra strobe within the same sweep.

// File: rtl/irq_router_pkg.sv
package irq_router_pkg;

  typedef enum logic [2:0] {
    OP_IDLE    = 3'd0,
    OP_PCI_SET = 3'd1,
    OP_PCI_CLR = 3'd2,
    OP_ISA_SET = 3'd3,
    OP_ISA_CLR = 3'd4,
    OP_ROUTE   = 3'd5
  } op_e;

  function automatic int line_of(int dev, int pin, int n_pin);
    return dev * n_pin + pin;
  endfunction

  function automatic int direct_gsi_of(int line, int base, int n_direct);
    return base + (line % n_direct);
  endfunction

  function automatic int link_of(int dev, int pin, int n_link);
    return (dev + pin) % n_link;
  endfunction

endpackage

// File: rtl/irq_line_latch.sv
module irq_line_latch #(
  parameter int N  = 16,
  parameter int IW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          set_en,
  input  logic          clr_en,
  input  logic [IW-1:0] idx,
  output logic          changed
);
  logic [N-1:0] held;
  logic         cur;

  assign cur     = held[idx];
  assign changed = (set_en && !cur) || (clr_en && cur);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) held <= '0;
    else if (changed) held[idx] <= set_en;
  end
endmodule

// File: rtl/irq_ref_counter_bank.sv
module irq_ref_counter_bank #(
  parameter int N = 4,
  parameter int W = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [N-1:0]   inc,
  input  logic [N-1:0]   dec,
  output logic [N*W-1:0] cnt_flat,
  output logic [N-1:0]   rise,
  output logic [N-1:0]   fall
);
  for (genvar i = 0; i < N; i++) begin : g_ent
    logic [W-1:0] cnt;
    logic         up, down;
    assign up   = inc[i] && !dec[i];
    assign down = dec[i] && !inc[i];
    assign rise[i] = up && (cnt == '0);
    assign fall[i] = down && (cnt == W'(1));
    assign cnt_flat[i*W +: W] = cnt;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    cnt <= '0;
      else if (up)   cnt <= cnt + W'(1);
      else if (down) cnt <= cnt - W'(1);
    end
  end
endmodule

// File: rtl/irq_route_table.sv
module irq_route_table #(
  parameter int N_LINK = 4,
  parameter int IRQ_W  = 4,
  parameter int LW     = $clog2(N_LINK)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_en,
  input  logic [LW-1:0]           wr_link,
  input  logic [IRQ_W-1:0]        wr_irq,
  output logic [N_LINK*IRQ_W-1:0] route_flat
);
  for (genvar l = 0; l < N_LINK; l++) begin : g_link
    logic [IRQ_W-1:0] route;
    assign route_flat[l*IRQ_W +: IRQ_W] = route;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) route <= '0;
      else if (wr_en && (wr_link == LW'(l))) route <= wr_irq;
    end
  end
endmodule

// File: rtl/irq_router.sv
module irq_router
  import irq_router_pkg::*;
#(
  parameter int N_DEV    = 32,
  parameter int N_PIN    = 4,
  parameter int N_ISA    = 16,
  parameter int N_LINK   = 4,
  parameter int N_DIRECT = 32,
  parameter int CNT_W    = 8,
  localparam int N_GSI   = N_ISA + N_DIRECT,
  localparam int N_LINE  = N_DEV * N_PIN,
  localparam int DEV_W   = $clog2(N_DEV),
  localparam int PIN_W   = $clog2(N_PIN),
  localparam int ISA_W   = $clog2(N_ISA),
  localparam int LINK_W  = $clog2(N_LINK),
  localparam int ROUTE_W = ISA_W + 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               op_valid,
  output logic               op_ready,
  input  logic [2:0]         op_code,
  input  logic [DEV_W-1:0]   op_dev,
  input  logic [PIN_W-1:0]   op_pin,
  input  logic [ISA_W-1:0]   op_isa,
  input  logic [LINK_W-1:0]  op_link,
  input  logic [ROUTE_W-1:0] op_route,
  output logic [N_GSI-1:0]   apic_rise,
  output logic [N_ISA-1:0]   pic_rise,
  output logic [N_ISA-1:0]   pic_fall
);
  localparam int LINE_W = $clog2(N_LINE);
  localparam int GSI_W  = $clog2(N_GSI);

  // decoded request
  logic accept, pci_set, pci_clr, isa_set, isa_clr, rt_wr;
  logic pci_chg, isa_chg;
  logic [LINE_W-1:0] line_idx;
  logic [GSI_W-1:0]  direct_gsi;
  logic [LINK_W-1:0] link_sel;
  logic [ISA_W-1:0]  cur_route, old_route, new_irq;

  // counter and table state brought out as named wires
  logic [N_GSI*CNT_W-1:0]  gsi_cnt_flat;
  logic [N_LINK*CNT_W-1:0] link_cnt_flat;
  logic [N_LINK*ISA_W-1:0] route_flat;
  logic [N_GSI-1:0]  gsi_inc, gsi_dec, gsi_rise, gsi_fall;
  logic [N_LINK-1:0] link_inc, link_dec, link_rise, link_fall;

  // route-move sequencing
  logic rt_legal, rt_do, rt_live, move_start;
  logic busy;
  logic [ISA_W-1:0] move_irq;

  assign op_ready = !busy;
  assign accept   = op_valid && op_ready;
  assign pci_set  = accept && (op_code == OP_PCI_SET);
  assign pci_clr  = accept && (op_code == OP_PCI_CLR);
  assign isa_set  = accept && (op_code == OP_ISA_SET);
  assign isa_clr  = accept && (op_code == OP_ISA_CLR);
  assign rt_wr    = accept && (op_code == OP_ROUTE);

  assign line_idx   = LINE_W'(line_of(int'(op_dev), int'(op_pin), N_PIN));
  assign direct_gsi = GSI_W'(direct_gsi_of(int'(line_idx), N_ISA, N_DIRECT));
  assign link_sel   = LINK_W'(link_of(int'(op_dev), int'(op_pin), N_LINK));
  assign cur_route  = route_flat[link_sel*ISA_W +: ISA_W];
  assign old_route  = route_flat[op_link*ISA_W +: ISA_W];
  assign new_irq    = op_route[ISA_W-1:0];

  assign rt_legal   = (op_route[ROUTE_W-1] == 1'b0);
  assign rt_do      = rt_wr && rt_legal && (old_route != new_irq);
  assign rt_live    = (link_cnt_flat[op_link*CNT_W +: CNT_W] != '0);
  assign move_start = rt_do && rt_live && (new_irq != '0);

  irq_line_latch #(.N(N_LINE)) u_pci_latch (
    .clk(clk), .rst_n(rst_n), .set_en(pci_set), .clr_en(pci_clr),
    .idx(line_idx), .changed(pci_chg)
  );

  irq_line_latch #(.N(N_ISA)) u_isa_latch (
    .clk(clk), .rst_n(rst_n), .set_en(isa_set), .clr_en(isa_clr),
    .idx(op_isa), .changed(isa_chg)
  );

  irq_route_table #(.N_LINK(N_LINK), .IRQ_W(ISA_W)) u_routes (
    .clk(clk), .rst_n(rst_n), .wr_en(rt_do), .wr_link(op_link),
    .wr_irq(new_irq), .route_flat(route_flat)
  );

  always_comb begin
    link_inc = '0;
    link_dec = '0;
    if (pci_set && pci_chg) link_inc[link_sel] = 1'b1;
    if (pci_clr && pci_chg) link_dec[link_sel] = 1'b1;
  end

  irq_ref_counter_bank #(.N(N_LINK), .W(CNT_W)) u_link_cnt (
    .clk(clk), .rst_n(rst_n), .inc(link_inc), .dec(link_dec),
    .cnt_flat(link_cnt_flat), .rise(link_rise), .fall(link_fall)
  );

  always_comb begin
    gsi_inc = '0;
    gsi_dec = '0;
    if (pci_set && pci_chg) begin
      gsi_inc[direct_gsi] = 1'b1;
      if (link_rise[link_sel] && (cur_route != '0))
        gsi_inc[GSI_W'(cur_route)] = 1'b1;
    end
    if (pci_clr && pci_chg) begin
      gsi_dec[direct_gsi] = 1'b1;
      if (link_fall[link_sel] && (cur_route != '0))
        gsi_dec[GSI_W'(cur_route)] = 1'b1;
    end
    if (isa_set && isa_chg) gsi_inc[GSI_W'(op_isa)] = 1'b1;
    if (isa_clr && isa_chg) gsi_dec[GSI_W'(op_isa)] = 1'b1;
    if (rt_do && rt_live && (old_route != '0))
      gsi_dec[GSI_W'(old_route)] = 1'b1;
    if (busy) gsi_inc[GSI_W'(move_irq)] = 1'b1;
  end

  irq_ref_counter_bank #(.N(N_GSI), .W(CNT_W)) u_gsi_cnt (
    .clk(clk), .rst_n(rst_n), .inc(gsi_inc), .dec(gsi_dec),
    .cnt_flat(gsi_cnt_flat), .rise(gsi_rise), .fall(gsi_fall)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy      <= 1'b0;
      move_irq  <= '0;
      apic_rise <= '0;
      pic_rise  <= '0;
      pic_fall  <= '0;
    end else begin
      busy <= move_start;
      if (move_start) move_irq <= new_irq;
      apic_rise <= gsi_rise;
      pic_rise  <= gsi_rise[N_ISA-1:0];
      pic_fall  <= gsi_fall[N_ISA-1:0];
    end
  end
endmodule

// File: rtl/irq_router_checker.sv
module irq_router_checker #(
  parameter int N_GSI = 48,
  parameter int N_ISA = 16,
  parameter int CNT_W = 8
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   op_valid,
  input logic                   op_ready,
  input logic [N_GSI-1:0]       apic_rise,
  input logic [N_ISA-1:0]       pic_rise,
  input logic [N_ISA-1:0]       pic_fall,
  input logic [N_GSI*CNT_W-1:0] gsi_cnt_flat
);
  AST_RISE_AT_MOST_TWO: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(apic_rise) <= 2); // R4

  AST_PIC_EDGE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    (pic_rise & pic_fall) == '0); // R5

  AST_MOVE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    !op_ready |=> op_ready); // R8

  AST_QUIET_NO_OP: assert property (@(posedge clk) disable iff (!rst_n)
    (op_ready && !op_valid) |=> (apic_rise == '0 && pic_rise == '0 && pic_fall == '0)); // R10

  for (genvar g = 0; g < N_GSI; g++) begin : g_gsi
    AST_RISE_COUNT_ONE: assert property (@(posedge clk) disable iff (!rst_n)
      apic_rise[g] |-> (gsi_cnt_flat[g*CNT_W +: CNT_W] == CNT_W'(1))); // R3
    AST_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
      (gsi_cnt_flat[g*CNT_W +: CNT_W] == '1) |=> (gsi_cnt_flat[g*CNT_W +: CNT_W] != '0)); // R11
  end

  for (genvar n = 0; n < N_ISA; n++) begin : g_isa
    AST_FALL_COUNT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      pic_fall[n] |-> (gsi_cnt_flat[n*CNT_W +: CNT_W] == '0)); // R5
  end
endmodule

bind irq_router irq_router_checker #(
  .N_GSI(N_GSI), .N_ISA(N_ISA), .CNT_W(CNT_W)
) u_irq_router_checker (
  .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_ready(op_ready),
  .apic_rise(apic_rise), .pic_rise(pic_rise), .pic_fall(pic_fall),
  .gsi_cnt_flat(gsi_cnt_flat)
);

// File: tb/test_irq_router.sv
`timescale 1ns/1ps
module test_irq_router;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        op_valid = 1'b0;
  logic        op_ready;
  logic [2:0]  op_code = '0;
  logic [4:0]  op_dev = '0;
  logic [1:0]  op_pin = '0;
  logic [3:0]  op_isa = '0;
  logic [1:0]  op_link = '0;
  logic [4:0]  op_route = '0;
  logic [47:0] apic_rise;
  logic [15:0] pic_rise, pic_fall;

  always #2 clk = ~clk;

  irq_router i_irq_router (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_ready(op_ready),
    .op_code(op_code), .op_dev(op_dev), .op_pin(op_pin), .op_isa(op_isa),
    .op_link(op_link), .op_route(op_route), .apic_rise(apic_rise),
    .pic_rise(pic_rise), .pic_fall(pic_fall)
  );

  int n_tests = 0;
  int n_fail  = 0;

  // reference state derived from the requirements
  bit m_pin[128];
  bit m_isa[16];
  int m_gsi[48];
  int m_link[4];
  int m_route[4];

  task automatic check(input string tag, input logic [47:0] ea,
                       input logic [15:0] er, input logic [15:0] ef, input logic erdy);
    n_tests++;
    if (apic_rise !== ea || pic_rise !== er || pic_fall !== ef || op_ready !== erdy) begin
      n_fail++;
      $display("FAIL %s apic=%h exp %h pic_rise=%h exp %h pic_fall=%h exp %h ready=%b exp %b",
               tag, apic_rise, ea, pic_rise, er, pic_fall, ef, op_ready, erdy);
    end
  endtask

  task automatic do_op(input int code, input int dev, input int pin, input int isa,
                       input int link, input int route, input string tag);
    logic [47:0] ea = '0, ea2 = '0;
    logic [15:0] er = '0, ef = '0, er2 = '0;
    bit two = 0;
    int idx, g, l, r, old;
    idx = dev * 4 + pin;
    g = 16 + (idx % 32);
    l = (dev + pin) % 4;
    r = m_route[l];
    case (code)
      1: if (!m_pin[idx]) begin
           m_pin[idx] = 1;
           if (m_gsi[g] == 0) ea[g] = 1;
           m_gsi[g]++;
           if (m_link[l] == 0 && r != 0) begin
             if (m_gsi[r] == 0) begin ea[r] = 1; er[r] = 1; end
             m_gsi[r]++;
           end
           m_link[l]++;
         end
      2: if (m_pin[idx]) begin
           m_pin[idx] = 0;
           m_gsi[g]--;
           m_link[l]--;
           if (m_link[l] == 0 && r != 0) begin
             m_gsi[r]--;
             if (m_gsi[r] == 0) ef[r] = 1;
           end
         end
      3: if (!m_isa[isa]) begin
           m_isa[isa] = 1;
           if (m_gsi[isa] == 0) begin ea[isa] = 1; er[isa] = 1; end
           m_gsi[isa]++;
         end
      4: if (m_isa[isa]) begin
           m_isa[isa] = 0;
           m_gsi[isa]--;
           if (m_gsi[isa] == 0) ef[isa] = 1;
         end
      5: if (route <= 15 && route != m_route[link]) begin
           old = m_route[link];
           m_route[link] = route;
           if (m_link[link] != 0) begin
             if (old != 0) begin
               m_gsi[old]--;
               if (m_gsi[old] == 0) ef[old] = 1;
             end
             if (route != 0) begin
               two = 1;
               if (m_gsi[route] == 0) begin ea2[route] = 1; er2[route] = 1; end
               m_gsi[route]++;
             end
           end
         end
      default: ;
    endcase
    @(negedge clk);
    op_code  = 3'(code);
    op_dev   = 5'(dev);
    op_pin   = 2'(pin);
    op_isa   = 4'(isa);
    op_link  = 2'(link);
    op_route = 5'(route);
    op_valid = 1'b1;
    @(negedge clk);
    op_valid = 1'b0;
    check(tag, ea, er, ef, !two);
    if (two) begin
      @(negedge clk);
      check(tag, ea2, er2, 16'h0, 1'b1);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    foreach (m_pin[i]) m_pin[i] = 0;
    foreach (m_isa[i]) m_isa[i] = 0;
    foreach (m_gsi[i]) m_gsi[i] = 0;
    foreach (m_link[i]) begin m_link[i] = 0; m_route[i] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 reset", '0, '0, '0, 1'b1);

    // R3 / R6: every pin with all links disconnected
    for (int d = 0; d < 32; d++)
      for (int p = 0; p < 4; p++) do_op(1, d, p, 0, 0, 0, "R3 direct assert");
    do_op(1, 0, 0, 0, 0, 0, "R2 repeat assert");
    do_op(1, 31, 3, 0, 0, 0, "R2 repeat assert");
    for (int d = 0; d < 32; d++)
      for (int p = 0; p < 4; p++) do_op(2, d, p, 0, 0, 0, "R5 direct release");
    do_op(2, 5, 1, 0, 0, 0, "R2 repeat deassert");

    // R8 / R9: routes written while links are idle
    do_op(5, 0, 0, 0, 0, 5, "R8 idle route");
    do_op(5, 0, 0, 0, 1, 9, "R8 idle route");
    do_op(5, 0, 0, 0, 2, 5, "R8 idle route");
    do_op(5, 0, 0, 0, 3, 0, "R8 same value");
    do_op(5, 0, 0, 0, 1, 20, "R9 illegal route");

    // R7 legacy line, then R4 routed sharing
    do_op(3, 0, 0, 5, 0, 0, "R7 legacy assert");
    do_op(3, 0, 0, 5, 0, 0, "R7 repeat legacy assert");
    for (int d = 0; d < 32; d++)
      for (int p = 0; p < 4; p++) do_op(1, d, p, 0, 0, 0, "R4 routed assert");

    // R8 live moves, R9 rejection
    do_op(5, 0, 0, 0, 1, 11, "R8 live move");
    do_op(5, 0, 0, 0, 1, 11, "R8 same value live");
    do_op(5, 0, 0, 0, 1, 17, "R9 illegal live");
    do_op(5, 0, 0, 0, 0, 0, "R8 disconnect live");
    do_op(5, 0, 0, 0, 3, 7, "R6 connect live");

    // R5 / R11 release with shared holders on IRQ 5
    for (int d = 0; d < 32; d++)
      for (int p = 0; p < 4; p++) do_op(2, d, p, 0, 0, 0, "R11 shared release");
    do_op(4, 0, 0, 5, 0, 0, "R7 legacy release");
    do_op(4, 0, 0, 5, 0, 0, "R7 repeat legacy release");
    do_op(3, 0, 0, 9, 0, 0, "R7 legacy assert 9");
    do_op(2, 1, 0, 0, 0, 0, "R2 deassert clear pin");
    do_op(4, 0, 0, 9, 0, 0, "R7 legacy release 9");

    // R10 ignored codes and idle cycles
    do_op(7, 3, 2, 4, 1, 3, "R10 unknown code");
    do_op(0, 3, 2, 4, 1, 3, "R10 idle code");
    do_op(1, 1, 2, 0, 0, 0, "R10 after unknown");
    repeat (2) begin
      @(negedge clk);
      check("R10 no request", '0, '0, '0, 1'b1);
    end
    do_op(2, 1, 2, 0, 0, 0, "R10 final release");

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule